// File: doc/BRIEF.md
# Tag-Matching Reservation Station

This block is a small pool of instruction slots that sits in front of one functional unit in an out-of-order core. When an operation is issued, it takes a free slot. The slot holds the operation code, the destination tag (the reorder-buffer index of the operation) and two source operands. Each source arrives either as a finished value or as the tag of the operation that will produce it. While a source is still pending, the slot compares its tag against every result broadcast on the common result bus and copies the value when the tags match.

A slot whose two sources are both values asks to dispatch. If several slots ask in the same cycle, the oldest one goes to the unit first. Age is tracked by an ordering matrix that is written at issue. A dispatched slot is not released at once. It stays occupied until its own result appears on the result bus. A flush input removes every slot whose destination tag is younger than the mispredicted branch. Age is measured against the current reorder-buffer head, so tag wrap-around is handled.

Top module: `rs_station`

## Requirements
- R1: After reset every slot is empty: `iss_ready` is 1 and `disp_valid` is 0. `iss_ready` is 1 exactly when at least one slot is empty.
- R2: An issue is accepted only when `iss_valid`, `iss_ready` and `rob_free` are all 1 and `flush_valid` is 0. Otherwise the issue request changes no slot and leads to no dispatch.
- R3: A source issued with its ready flag at 1 reaches the unit unchanged on `disp_a`/`disp_b`, together with the issued `disp_op` and `disp_dst`.
- R4: A pending source takes `bus_data` in the cycle when `bus_valid` is 1 and `bus_tag` equals its producer tag. The slot can dispatch from the following cycle on, and not before.
- R5: If a result broadcast occurs in the same cycle as the issue of an operation that waits on that tag, the value is captured into the new slot.
- R6: `disp_valid` is 1 only when some slot holds two values. Once it is 1, it stays 1 until `disp_ready` is taken or a flush occurs.
- R7: When several slots are ready, the one issued earliest is dispatched first, no matter which slot index it occupies.
- R8: A dispatched slot stays occupied until the result bus carries its destination tag, and is empty from the next cycle on. Slots are released only by a result broadcast or a flush.
- R9: When `flush_valid` is 1, every slot whose destination tag is younger than `flush_tag` is emptied. Age is the distance `(tag - rob_head) mod 2^TAG_W`. The branch and older slots are kept. Flushed operations never dispatch.
- R10: During a flush cycle, a slot being flushed is not offered for dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code to issue |
| iss_dst | input | TAG_W | Destination tag of the issued operation |
| iss_a_rdy | input | 1 | Source A is a value (1) or a tag (0) |
| iss_a_tag | input | TAG_W | Producer tag of source A |
| iss_a_val | input | DATA_W | Value of source A |
| iss_b_rdy | input | 1 | Source B is a value (1) or a tag (0) |
| iss_b_tag | input | TAG_W | Producer tag of source B |
| iss_b_val | input | DATA_W | Value of source B |
| rob_free | input | 1 | A reorder slot is available |
| iss_ready | output | 1 | At least one station slot is empty |
| bus_valid | input | 1 | Result broadcast valid |
| bus_tag | input | TAG_W | Tag of the broadcast result |
| bus_data | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | An operation is offered to the unit |
| disp_ready | input | 1 | Unit accepts the offered operation |
| disp_op | output | OP_W | Dispatched operation code |
| disp_dst | output | TAG_W | Dispatched destination tag |
| disp_a | output | DATA_W | Dispatched source A value |
| disp_b | output | DATA_W | Dispatched source B value |
| flush_valid | input | 1 | Flush younger operations |
| flush_tag | input | TAG_W | Tag of the flushing branch |
| rob_head | input | TAG_W | Current oldest reorder tag, used for age comparison |

## Verification
An issue with both sources ready appears on the dispatch port in the cycle after the issue edge. A broadcast that completes the last source of a slot makes it dispatchable one cycle after the broadcast edge. A freed slot shows on `iss_ready` one cycle after the broadcast of its tag. Flush masking acts in the flush cycle itself. The bench drives inputs just after a rising edge and samples at the falling edge, so each check lands in the exact cycle these delays give. The monitor pops one expected item for each accepted dispatch, so an early, late, reordered or extra dispatch shows up as a mismatch or an unexpected item.

// File: rtl/rs_pkg.sv
package rs_pkg;
    parameter int DATA_W = 16;
    parameter int TAG_W  = 4;
    parameter int OP_W   = 4;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_EXEC  = 2'd2
    } slot_state_e;

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } operand_t;

    typedef struct packed {
        slot_state_e       st;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  dst;
        operand_t          a;
        operand_t          b;
    } slot_t;

    // Capture a broadcast result into a pending operand on tag match.
    function automatic operand_t snoop(operand_t o, logic bv,
                                       logic [TAG_W-1:0] bt,
                                       logic [DATA_W-1:0] bd);
        operand_t r;
        r = o;
        if (!o.rdy && bv && (bt == o.tag)) begin
            r.rdy = 1'b1;
            r.val = bd;
        end
        return r;
    endfunction

    // True when tag was allocated after ref_tag, relative to the head.
    function automatic logic is_younger(logic [TAG_W-1:0] tag,
                                        logic [TAG_W-1:0] ref_tag,
                                        logic [TAG_W-1:0] head);
        logic [TAG_W-1:0] d_tag;
        logic [TAG_W-1:0] d_ref;
        d_tag = tag - head;
        d_ref = ref_tag - head;
        return d_tag > d_ref;
    endfunction
endpackage

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] occ,
    output logic [N-1:0] pick,
    output logic         any_free
);
    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < N; i++) begin
            if (!occ[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
        any_free = found;
    end
endmodule

// File: rtl/rs_age_matrix.sv
module rs_age_matrix #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] alloc,
    input  logic [N-1:0] occ,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    // older_q[i][j] = 1 : slot i was issued before slot j
    logic [N-1:0] older_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) older_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (alloc[i])
                        older_q[i][j] <= 1'b0;
                    else if (alloc[j])
                        older_q[i][j] <= occ[i];
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (req[j] && older_q[j][i]) blocked = 1'b1;
            end
            grant[i] = req[i] && !blocked;
        end
    end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  slot_t             load_data,
    input  logic              fire,
    input  logic              kill,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output slot_t             q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_data;
        end else if (kill) begin
            q.st <= SLOT_EMPTY;
        end else begin
            case (q.st)
                SLOT_WAIT: begin
                    q.a <= snoop(q.a, bus_valid, bus_tag, bus_data);
                    q.b <= snoop(q.b, bus_valid, bus_tag, bus_data);
                    if (fire) q.st <= SLOT_EXEC;
                end
                SLOT_EXEC: begin
                    if (bus_valid && bus_tag == q.dst) q.st <= SLOT_EMPTY;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_dst,
    input  logic              iss_a_rdy,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic              iss_b_rdy,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic [DATA_W-1:0] iss_b_val,
    input  logic              rob_free,
    output logic              iss_ready,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [OP_W-1:0]   disp_op,
    output logic [TAG_W-1:0]  disp_dst,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    input  logic              flush_valid,
    input  logic [TAG_W-1:0]  flush_tag,
    input  logic [TAG_W-1:0]  rob_head
);
    localparam int N = NUM_SLOTS;

    slot_t                slots [N];
    slot_t                new_slot;
    logic [N-1:0]         occ;
    logic [N-1:0]         ready;
    logic [N-1:0]         kill;
    logic [N-1:0]         pick;
    logic [N-1:0]         alloc;
    logic [N-1:0]         grant;
    logic [N*TAG_W-1:0]   dst_flat;
    logic                 any_free;
    logic                 iss_fire;

    assign iss_fire  = iss_valid && any_free && rob_free && !flush_valid;
    assign iss_ready = any_free;
    assign alloc     = iss_fire ? pick : '0;

    always_comb begin
        new_slot.st  = SLOT_WAIT;
        new_slot.op  = iss_op;
        new_slot.dst = iss_dst;
        new_slot.a   = snoop('{rdy: iss_a_rdy, tag: iss_a_tag, val: iss_a_val},
                             bus_valid, bus_tag, bus_data);
        new_slot.b   = snoop('{rdy: iss_b_rdy, tag: iss_b_tag, val: iss_b_val},
                             bus_valid, bus_tag, bus_data);
    end

    rs_free_pick #(.N(N)) u_pick (
        .occ      (occ),
        .pick     (pick),
        .any_free (any_free)
    );

    for (genvar g = 0; g < N; g++) begin : g_slot
        rs_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .load      (alloc[g]),
            .load_data (new_slot),
            .fire      (grant[g] && disp_ready),
            .kill      (kill[g]),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_data  (bus_data),
            .q         (slots[g])
        );
        assign occ[g]   = (slots[g].st != SLOT_EMPTY);
        assign kill[g]  = flush_valid && occ[g] &&
                          is_younger(slots[g].dst, flush_tag, rob_head);
        assign ready[g] = (slots[g].st == SLOT_WAIT) && slots[g].a.rdy &&
                          slots[g].b.rdy && !kill[g];
        assign dst_flat[g*TAG_W +: TAG_W] = slots[g].dst;
    end

    rs_age_matrix #(.N(N)) u_age (
        .clk   (clk),
        .rst   (rst),
        .alloc (alloc),
        .occ   (occ),
        .req   (ready),
        .grant (grant)
    );

    always_comb begin
        disp_op  = '0;
        disp_dst = '0;
        disp_a   = '0;
        disp_b   = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                disp_op  = disp_op  | slots[i].op;
                disp_dst = disp_dst | slots[i].dst;
                disp_a   = disp_a   | slots[i].a.val;
                disp_b   = disp_b   | slots[i].b.val;
            end
        end
        disp_valid = |grant;
    end
endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk
    import rs_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       iss_ready,
    input logic                       iss_fire,
    input logic                       disp_valid,
    input logic                       disp_ready,
    input logic                       flush_valid,
    input logic                       bus_valid,
    input logic [TAG_W-1:0]           flush_tag,
    input logic [TAG_W-1:0]           rob_head,
    input logic [NUM_SLOTS-1:0]       occ,
    input logic [NUM_SLOTS-1:0]       grant,
    input logic [NUM_SLOTS*TAG_W-1:0] dst_flat
);
    logic                 flush_q;
    logic [TAG_W-1:0]     ftag_q;
    logic [TAG_W-1:0]     head_q;
    logic [NUM_SLOTS-1:0] young_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_q <= 1'b0;
            ftag_q  <= '0;
            head_q  <= '0;
        end else begin
            flush_q <= flush_valid;
            ftag_q  <= flush_tag;
            head_q  <= rob_head;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++)
            young_left[i] = occ[i] &&
                is_younger(dst_flat[i*TAG_W +: TAG_W], ftag_q, head_q);
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (iss_ready && !disp_valid));

    p_no_grow_r2: assert property (@(posedge clk) disable iff (rst)
        !iss_fire |=> ($countones(occ) <= $past($countones(occ))));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !disp_ready && !flush_valid) |=> (disp_valid || flush_valid));

    p_single_grant_r7: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> ($countones(grant) == 1));

    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (!bus_valid && !flush_valid) |=> ($countones(occ) >= $past($countones(occ))));

    p_flush_clean_r9: assert property (@(posedge clk) disable iff (rst)
        flush_q |-> (young_left == '0));
endmodule

bind rs_station rs_station_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .iss_ready   (iss_ready),
    .iss_fire    (iss_fire),
    .disp_valid  (disp_valid),
    .disp_ready  (disp_ready),
    .flush_valid (flush_valid),
    .bus_valid   (bus_valid),
    .flush_tag   (flush_tag),
    .rob_head    (rob_head),
    .occ         (occ),
    .grant       (grant),
    .dst_flat    (dst_flat)
);

// File: tb/tb_rs_station.sv
`timescale 1ns/1ps
module tb_rs_station;
    import rs_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              iss_valid = 1'b0;
    logic [OP_W-1:0]   iss_op = '0;
    logic [TAG_W-1:0]  iss_dst = '0;
    logic              iss_a_rdy = 1'b0;
    logic [TAG_W-1:0]  iss_a_tag = '0;
    logic [DATA_W-1:0] iss_a_val = '0;
    logic              iss_b_rdy = 1'b0;
    logic [TAG_W-1:0]  iss_b_tag = '0;
    logic [DATA_W-1:0] iss_b_val = '0;
    logic              rob_free = 1'b1;
    logic              iss_ready;
    logic              bus_valid = 1'b0;
    logic [TAG_W-1:0]  bus_tag = '0;
    logic [DATA_W-1:0] bus_data = '0;
    logic              disp_valid;
    logic              disp_ready = 1'b1;
    logic [OP_W-1:0]   disp_op;
    logic [TAG_W-1:0]  disp_dst;
    logic [DATA_W-1:0] disp_a;
    logic [DATA_W-1:0] disp_b;
    logic              flush_valid = 1'b0;
    logic [TAG_W-1:0]  flush_tag = '0;
    logic [TAG_W-1:0]  rob_head = '0;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  dst;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } item_t;

    item_t exp_q [$];
    string req_q [$];

    always #10 clk = ~clk;

    rs_station #(.NUM_SLOTS(4)) dut (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic expect_disp(input int op, input int dst, input int a,
                               input int b, input string req);
        item_t it;
        it.op  = OP_W'(op);
        it.dst = TAG_W'(dst);
        it.a   = DATA_W'(a);
        it.b   = DATA_W'(b);
        exp_q.push_back(it);
        req_q.push_back(req);
    endtask

    task automatic issue(input int op, input int dst,
                         input bit ar, input int at, input int av,
                         input bit br, input int bt, input int bv);
        iss_valid = 1'b1;
        iss_op    = OP_W'(op);
        iss_dst   = TAG_W'(dst);
        iss_a_rdy = ar;
        iss_a_tag = TAG_W'(at);
        iss_a_val = DATA_W'(av);
        iss_b_rdy = br;
        iss_b_tag = TAG_W'(bt);
        iss_b_val = DATA_W'(bv);
        tick();
        iss_valid = 1'b0;
    endtask

    task automatic bcast(input int tag, input int data);
        bus_valid = 1'b1;
        bus_tag   = TAG_W'(tag);
        bus_data  = DATA_W'(data);
        tick();
        bus_valid = 1'b0;
    endtask

    task automatic flush(input int tag, input int head);
        flush_valid = 1'b1;
        flush_tag   = TAG_W'(tag);
        rob_head    = TAG_W'(head);
        tick();
        flush_valid = 1'b0;
    endtask

    // Monitor: pops one expected item per accepted dispatch.
    always @(negedge clk) begin
        if (!rst && disp_valid && disp_ready) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R9 unexpected dispatch dst %0d: got 1 expected 0", disp_dst);
            end else begin
                item_t e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(disp_dst == e.dst, r, "disp_dst", disp_dst, e.dst);
                check(disp_op  == e.op,  r, "disp_op",  disp_op,  e.op);
                check(disp_a   == e.a,   r, "disp_a",   disp_a,   e.a);
                check(disp_b   == e.b,   r, "disp_b",   disp_b,   e.b);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        @(negedge clk);
        check(iss_ready && !disp_valid, "R1", "idle after reset",
              {iss_ready, disp_valid}, 2);

        // R3: both sources ready, dispatched one cycle after issue
        expect_disp(1, 1, 10, 20, "R3");
        issue(1, 1, 1, 0, 10, 1, 0, 20);
        issue(2, 2, 0, 9, 0, 1, 0, 5);
        issue(3, 3, 1, 0, 7, 0, 9, 0);
        issue(4, 4, 0, 10, 0, 1, 0, 3);
        @(negedge clk);
        check(iss_ready == 1'b0, "R8", "full while tag1 executes", iss_ready, 0);

        // R2: issue ignored while full
        issue(5, 13, 1, 0, 1, 1, 0, 1);
        bcast(1, 111);
        @(negedge clk);
        check(iss_ready == 1'b1, "R8", "slot released by result", iss_ready, 1);

        // R7: youngest goes into slot 0, oldest ready still first
        issue(5, 5, 0, 9, 0, 1, 0, 9);
        expect_disp(2, 2, 100, 5, "R7");
        expect_disp(3, 3, 7, 100, "R4");
        expect_disp(5, 5, 100, 9, "R7");
        bcast(9, 100);
        repeat (4) tick();
        bcast(2, 0);
        bcast(3, 0);
        bcast(5, 0);

        // R5: result broadcast in the issue cycle
        expect_disp(6, 6, 55, 6, "R5");
        iss_valid = 1'b1; iss_op = 4'd6; iss_dst = 4'd6;
        iss_a_rdy = 1'b0; iss_a_tag = 4'd11; iss_a_val = '0;
        iss_b_rdy = 1'b1; iss_b_tag = '0; iss_b_val = 16'd6;
        bus_valid = 1'b1; bus_tag = 4'd11; bus_data = 16'd55;
        tick();
        iss_valid = 1'b0; bus_valid = 1'b0;
        repeat (3) tick();

        // R2: no reorder slot -> no issue
        rob_free = 1'b0;
        issue(7, 14, 1, 0, 1, 1, 0, 2);
        rob_free = 1'b1;
        @(negedge clk);
        check(disp_valid == 1'b0, "R2", "issue without reorder slot", disp_valid, 0);
        bcast(6, 0);

        // R9: flush removes younger tag8, keeps branch tag7 and older tag4
        issue(7, 7, 0, 12, 0, 1, 0, 1);
        issue(8, 8, 0, 12, 0, 1, 0, 2);
        flush(7, 0);
        expect_disp(7, 7, 16'h1212, 1, "R9");
        expect_disp(4, 4, 16'h0AAA, 3, "R9");
        bcast(12, 16'h1212);
        bcast(10, 16'h0AAA);
        repeat (3) tick();

        // R6: offer held while unit stalls; R10: masked in flush cycle
        disp_ready = 1'b0;
        issue(9, 9, 1, 0, 9, 1, 0, 9);
        @(negedge clk);
        check(disp_valid == 1'b1, "R6", "offer visible", disp_valid, 1);
        tick();
        @(negedge clk);
        check(disp_valid == 1'b1, "R6", "offer held under stall", disp_valid, 1);
        tick();
        flush_valid = 1'b1; flush_tag = 4'd8; rob_head = 4'd0;
        disp_ready  = 1'b1;
        @(negedge clk);
        check(disp_valid == 1'b0, "R10", "killed slot not offered", disp_valid, 0);
        tick();
        flush_valid = 1'b0;
        @(negedge clk);
        check(disp_valid == 1'b0, "R9", "flushed slot gone", disp_valid, 0);
        bcast(4, 0);
        bcast(7, 0);

        // R9: wrap-around age, head=14: tag1 is younger than tag15
        issue(10, 15, 0, 13, 0, 1, 0, 1);
        issue(11, 1, 0, 13, 0, 1, 0, 2);
        flush(15, 14);
        expect_disp(10, 15, 77, 1, "R9");
        bcast(13, 77);
        repeat (5) tick();
        check(exp_q.size() == 0, "R9", "pending expected dispatches",
              exp_q.size(), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule